// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel digital-to-analog converter. A host writes a frame over a three-wire serial port made of an active-low chip select, a serial clock and a data line. Each frame carries a 2-bit channel address followed by a data word, most significant bit first. When chip select is released, the address picks which channel input registers, if any, take the data word.

Each channel also has a second-stage DAC register, and the two DAC register words are the outputs. An active-low load-DAC input makes the second stage follow the input registers while it is low and freeze while it is high. Tying it low gives a single-buffered interface. Holding it high lets both channels be staged and then updated together.

An active-low asynchronous reset forces all four registers to zero or to midscale, selected by a pin. The serial data is captured in the serial-clock domain. The chip-select release and the load-DAC level are synchronized into a system clock before they touch the registers. The data width is a parameter, 14 or 16 bits.

Top module: `dual_dac_serial_if`

## Requirements
- R1: A frame is DATA_W+2 bits long: address bit 1, address bit 0, then data bit DATA_W-1 down to data bit 0. Each rising edge of the serial clock while chip select is low shifts in one bit from the data line.
- R2: Serial clock edges while chip select is high do not change the shift register. A chip-select low pulse with no clock edge therefore reloads the last complete frame.
- R3: Only the last DATA_W+2 bits clocked in before chip select rises are used. Surplus bits clocked in earlier are discarded.
- R4: On the rising edge of chip select, the address selects the target: 2'b00 writes no channel, 2'b01 writes channel A, 2'b10 writes channel B and 2'b11 writes both. The write takes place at the third system clock rising edge after the chip-select edge.
- R5: While load-DAC is low, each DAC register takes its input register value one system clock after the synchronized level is seen. A new frame therefore appears at the outputs within ten system clocks.
- R6: While load-DAC is high, both DAC registers hold their value, even when a frame changes the input registers. Those values appear once load-DAC goes low.
- R7: While reset is low, the input and DAC registers of both channels are forced to 0 when the midscale select is 0. They are forced to 1 << (DATA_W-1) (0x8000 for 16 bits, 0x2000 for 14 bits) when it is 1.
- R8: Reset overrides both a chip-select release and load-DAC transparency that occur while it is low. No write from such a frame reaches any register after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the synchronizers and the channel registers |
| rstN | input | 1 | Asynchronous active-low reset to the code chosen by midSel |
| midSel | input | 1 | Reset code select: 0 gives zero, 1 gives midscale |
| csN | input | 1 | Active-low serial chip select; its rising edge loads a frame |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| ldacN | input | 1 | Active-low load-DAC level; low makes the DAC registers transparent |
| dacA | output | DATA_W | DAC register word of channel A |
| dacB | output | DATA_W | DAC register word of channel B |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is a chip-select load and the load-DAC transfer. With load-DAC held low, the synchronized load strobe writes an input register in the same clock in which the transparent DAC stage samples it. The DAC word is judged ten clocks later against the frame's expected value, and a checker requires every DAC word to equal the input register of the previous cycle. The second pair is reset and chip select: chip select is raised while reset is low. The outputs must then show the reset code both during reset and after it is released, never the frame's data.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Strobes sent from the control unit to the datapath each system clock.
  typedef struct packed {
    logic loadA;    // write channel A input register
    logic loadB;    // write channel B input register
    logic xferDac;  // DAC registers follow input registers
  } dacStrobe_t;

  function automatic logic [1:0] decodeTargets(input logic [1:0] addr);
    logic [1:0] sel;
    case (addr)
      2'b01:   sel = 2'b01;
      2'b10:   sel = 2'b10;
      2'b11:   sel = 2'b11;
      default: sel = 2'b00;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       ldacN,
  input  logic [1:0] frameAddr,
  output dacStrobe_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] csChain;
  logic [LAST:0] ldacChain;
  logic          csPrev;
  logic          csRise;
  logic [1:0]    target;

  // Chip-select synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csChain <= '1;
      csPrev  <= 1'b1;
    end else begin
      csChain <= {csChain[LAST-1:0], csN};
      csPrev  <= csChain[LAST];
    end
  end

  // Load-DAC synchronizer, resets to the holding level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldacChain <= '1;
    end else begin
      ldacChain <= {ldacChain[LAST-1:0], ldacN};
    end
  end

  always_comb begin
    csRise       = csChain[LAST] & ~csPrev;
    target       = decodeTargets(frameAddr);
    strb.loadA   = csRise & target[0];
    strb.loadB   = csRise & target[1];
    strb.xferDac = ~ldacChain[LAST];
  end

endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              midSel,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  dacStrobe_t        strb,
  output logic [1:0]        frameAddr,
  output logic [DATA_W-1:0] inA,
  output logic [DATA_W-1:0] inB,
  output logic [DATA_W-1:0] dacA,
  output logic [DATA_W-1:0] dacB
);

  localparam int FRAME_W = DATA_W + 2;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [FRAME_W-1:0] shReg;
  logic [DATA_W-1:0]  rstCode;
  logic [DATA_W-1:0]  frameData;

  assign rstCode   = midSel ? MID_CODE : '0;
  assign frameAddr = shReg[FRAME_W-1 -: 2];
  assign frameData = shReg[DATA_W-1:0];

  // Serial capture in the serial-clock domain; a full frame is kept
  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (!csN) begin
      shReg <= {shReg[FRAME_W-2:0], sdi};
    end
  end

  // Input registers, written from the settled frame after chip-select release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inA <= rstCode;
      inB <= rstCode;
    end else begin
      if (strb.loadA) inA <= frameData;
      if (strb.loadB) inB <= frameData;
    end
  end

  // Second stage, transparent while the synchronized load-DAC is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacA <= rstCode;
      dacB <= rstCode;
    end else if (strb.xferDac) begin
      dacA <= inA;
      dacB <= inB;
    end
  end

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dacif_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              midSel,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              ldacN,
  output logic [DATA_W-1:0] dacA,
  output logic [DATA_W-1:0] dacB
);

  dacStrobe_t        strb;
  logic [1:0]        frameAddr;
  logic [DATA_W-1:0] inA;
  logic [DATA_W-1:0] inB;

  dacif_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .ldacN     (ldacN),
    .frameAddr (frameAddr),
    .strb      (strb)
  );

  dacif_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .midSel    (midSel),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .strb      (strb),
    .frameAddr (frameAddr),
    .inA       (inA),
    .inB       (inB),
    .dacA      (dacA),
    .dacB      (dacB)
  );

endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input dacStrobe_t        strb,
  input logic [DATA_W-1:0] inA,
  input logic [DATA_W-1:0] inB,
  input logic [DATA_W-1:0] dacA,
  input logic [DATA_W-1:0] dacB
);

  // R5: a transparent cycle copies the input registers
  p_dac_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferDac |=> (dacA == $past(inA)) && (dacB == $past(inB)));

  // R6: with the transfer strobe low the DAC words stay put
  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xferDac |=> $stable(dacA) && $stable(dacB));

  // R4: input registers change only on their own load strobe
  p_in_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadA |=> $stable(inA)) and (!strb.loadB |=> $stable(inB)));

  // R4: one chip-select release gives a single-cycle load
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadA || strb.loadB) |=> !(strb.loadA || strb.loadB));

endmodule

bind dual_dac_serial_if dacif_checker #(.DATA_W(DATA_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .strb (strb),
  .inA  (inA),
  .inB  (inB),
  .dacA (dacA),
  .dacB (dacB)
);

// File: tb/tb_dual_dac_serial_if.sv
module tb_dual_dac_serial_if;

  localparam int DW = 16;
  localparam int FW = DW + 2;
  localparam int NVEC = 8;

  // {addr, data, expected dacA, expected dacB}, ldacN held low
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b01, 16'h1234, 16'h1234, 16'h0000},
    {2'b10, 16'hABCD, 16'h1234, 16'hABCD},
    {2'b11, 16'h5A5A, 16'h5A5A, 16'h5A5A},
    {2'b00, 16'hFFFF, 16'h5A5A, 16'h5A5A},
    {2'b01, 16'h0001, 16'h0001, 16'h5A5A},
    {2'b10, 16'h8000, 16'h0001, 16'h8000},
    {2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {2'b01, 16'h0000, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b1;
  logic midSel = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic ldacN = 1'b0;
  logic [DW-1:0] dacA;
  logic [DW-1:0] dacB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  dual_dac_serial_if #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .midSel(midSel), .csN(csN), .sclk(sclk),
    .sdi(sdi), .ldacN(ldacN), .dacA(dacA), .dacB(dacB)
  );

  task automatic check(input string req, input logic [DW-1:0] ea, input logic [DW-1:0] eb);
    total++;
    if (dacA !== ea || dacB !== eb) begin
      bad++;
      $display("FAIL %s: dacA=%h dacB=%h expected dacA=%h dacB=%h", req, dacA, dacB, ea, eb);
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseBit(input logic b);
    sdi = b;
    #10 sclk = 1'b1;
    #10 sclk = 1'b0;
  endtask

  task automatic shiftFrame(input logic [1:0] addr, input logic [DW-1:0] data);
    logic [FW-1:0] word;
    word = {addr, data};
    for (int i = FW - 1; i >= 0; i--) pulseBit(word[i]);
  endtask

  task automatic sendFrame(input logic [1:0] addr, input logic [DW-1:0] data);
    csN = 1'b0;
    #10;
    shiftFrame(addr, data);
    #10 csN = 1'b1;
    settle();
  endtask

  initial begin
    #5 rstN = 1'b0;
    settle();
    check("R7 zero code during reset", 16'h0000, 16'h0000);
    #1 rstN = 1'b1;
    settle();
    check("R7 zero code after reset", 16'h0000, 16'h0000);

    // R1 R4 R5: table walk, load-DAC transparent
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VEC[v][49:48], VEC[v][47:32]);
      check($sformatf("R1/R4/R5 vector %0d", v), VEC[v][31:16], VEC[v][15:0]);
    end

    // R2: clock edges with chip select high, then an empty select pulse
    sendFrame(2'b01, 16'h1111);
    sendFrame(2'b10, 16'h2222);
    for (int k = 0; k < 8; k++) pulseBit(1'b1);
    settle();
    check("R2 idle clocks leave outputs", 16'h1111, 16'h2222);
    csN = 1'b0;
    #20 csN = 1'b1;
    settle();
    check("R2 empty pulse reloads last frame", 16'h1111, 16'h2222);

    // R3: surplus leading bits
    csN = 1'b0;
    #10;
    for (int k = 0; k < 5; k++) pulseBit(1'b1);
    shiftFrame(2'b01, 16'h3C3C);
    #10 csN = 1'b1;
    settle();
    check("R3 surplus bits discarded", 16'h3C3C, 16'h2222);

    // R6 then R5: staged update
    ldacN = 1'b1;
    settle();
    sendFrame(2'b11, 16'h7777);
    check("R6 load-DAC high holds", 16'h3C3C, 16'h2222);
    sendFrame(2'b01, 16'h0F0F);
    check("R6 second frame still held", 16'h3C3C, 16'h2222);
    ldacN = 1'b0;
    settle();
    check("R5 release shows staged words", 16'h0F0F, 16'h7777);

    // R7: zero reset mid-run
    #1 rstN = 1'b0;
    settle();
    check("R7 zero reset clears", 16'h0000, 16'h0000);
    #1 rstN = 1'b1;
    settle();

    // R8 with R7 midscale: chip select rises during reset
    sendFrame(2'b11, 16'h4444);
    check("R8 setup frame", 16'h4444, 16'h4444);
    csN = 1'b0;
    #10;
    shiftFrame(2'b11, 16'h1357);
    midSel = 1'b1;
    #3 rstN = 1'b0;
    #3 csN = 1'b1;
    settle();
    check("R7 midscale during reset", 16'h8000, 16'h8000);
    #1 rstN = 1'b1;
    settle();
    check("R8 reset beats chip-select load", 16'h8000, 16'h8000);

    // After R8: normal writes resume
    sendFrame(2'b10, 16'h0BAD);
    check("R4 write after reset", 16'h8000, 16'h0BAD);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400us;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected finish before timeout");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule